// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Flag Unit

This unit sits beside a time-of-day counter and keeps the interrupt state of a real-time clock. Each time the counter signals that an update cycle has finished, the unit records an update-ended event. It compares the freshly updated seconds, minutes and hours bytes against three alarm bytes and records an alarm event when they agree. A separate periodic tick records a periodic event. These three event flags, plus a summary interrupt flag, form a status byte. The status byte clears itself when it is read.

Three of the four bits in a control word enable interrupts: one for update, one for alarm and one for periodic. The fourth bit is a square-wave enable that is only stored. The interrupt line follows the summary flag. The line rises when an event sets a flag that was not already set and whose enable is on. It also rises at once when software turns on an enable whose flag is already pending.

Time and alarm bytes arrive in the same encoding. Computing the time and decoding the bus are outside this unit.

Top module: `rtc_alarm_irq`

## Requirements
- R1: An alarm byte whose bits 7:6 are both 1 is a wildcard and matches any current value of its field.
- R2: On every `upd_done` pulse (when the divider is not held), the update-ended flag (status bit 4) is set.
- R3: In the same update cycle, the alarm flag (status bit 5) is set when every non-wildcard alarm byte equals its current-time byte. A single mismatching byte leaves it clear.
- R4: When an event newly sets a flag whose enable is on, the summary flag (status bit 7) and `irq` are asserted in the cycle after the event. Control bits: 0 update, 1 alarm, 2 periodic, 3 square wave.
- R5: A `stat_rd` pulse returns the current status on `stat_q` in that cycle. In the next cycle all flags are zero and `irq` is low.
- R6: A control write that enables a flag already pending raises `irq` and status bit 7 in the next cycle. A control write that enables no pending flag clears status bit 7 and lowers `irq`.
- R7: With `mode_12h` = 1, bit 7 of the hours bytes (PM) must agree for an hour match. With `mode_12h` = 0, hour bit 7 is ignored.
- R8: Reset clears all four control bits, all status flags and `irq`.
- R9: While `div_hold` is 1, `upd_done` sets neither the update-ended flag nor the alarm flag.
- R10: A `per_tick` pulse sets the periodic flag (status bit 6) whether or not its enable is on. Status bits 3:0 always read zero.
- R11: An event that arrives in the same cycle as a status read is not lost. Its flag is set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_done | input | 1 | Update cycle complete strobe |
| per_tick | input | 1 | Periodic event strobe |
| div_hold | input | 1 | Divider held in reset; suppresses update and alarm events |
| mode_12h | input | 1 | 1 = hours byte uses 12-hour format with PM in bit 7 |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: {sqw, per, alm, upd} |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| ctrl_q | output | 4 | Current control word |
| stat_q | output | 8 | Status byte {irqf, pf, af, uf, 4'b0} |
| irq | output | 1 | Interrupt line, active high |

## Verification
A wrong flag register shows on `stat_q` in the first cycle after the triggering strobe. A broken enable or pending comparison shows on `irq` in that same cycle. A read clear that drops a coincident event leaves a flag missing one cycle after the read, so the bench samples each strobe's effect exactly one edge later. A comparator that ignores the wildcard rule or the PM bit shows as a missing or spurious alarm flag on the very update cycle being compared. Tests therefore pair matching and near-miss time values.

// File: rtl/rtcai_pkg.sv
package rtcai_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_FLD    = 3;
  localparam int N_EVT    = 3;
  localparam int N_CTL    = 4;
  // event / enable bit order: 0 update, 1 alarm, 2 periodic
  localparam int EV_UPD   = 0;
  localparam int EV_ALM   = 1;
  localparam int EV_PER   = 2;
  localparam int CTL_SQW  = 3;
  // field order inside the packed time vector
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HR   = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic logic is_wild(input byte_t b);
    return b[BYTE_W-1:BYTE_W-2] == 2'b11;
  endfunction

  function automatic logic field_hit(input byte_t alm, input byte_t cur);
    return is_wild(alm) || (alm == cur);
  endfunction

  function automatic logic hour_hit(input byte_t alm, input byte_t cur,
                                    input logic mode12);
    if (is_wild(alm)) return 1'b1;
    if (mode12) return alm == cur;
    return alm[BYTE_W-2:0] == cur[BYTE_W-2:0];
  endfunction

  function automatic byte_t pack_status(input logic irqf,
                                        input logic [N_EVT-1:0] fl);
    return {irqf, fl[EV_PER], fl[EV_ALM], fl[EV_UPD], 4'b0000};
  endfunction
endpackage

// File: rtl/rtcai_alarm_match.sv
module rtcai_alarm_match
  import rtcai_pkg::*;
#(
  parameter int NFLD = N_FLD,
  parameter int HOUR_IDX = FLD_HR
) (
  input  logic [NFLD-1:0][BYTE_W-1:0] alm,
  input  logic [NFLD-1:0][BYTE_W-1:0] cur,
  input  logic                        mode_12h,
  output logic                        hit
);
  logic [NFLD-1:0] fld_ok;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    if (i == HOUR_IDX) begin : g_hour
      assign fld_ok[i] = hour_hit(alm[i], cur[i], mode_12h);
    end else begin : g_plain
      assign fld_ok[i] = field_hit(alm[i], cur[i]);
    end
  end

  assign hit = &fld_ok;

  // R1: a field with a wildcard alarm byte never blocks a match
  always_comb begin
    for (int k = 0; k < NFLD; k++)
      if (is_wild(alm[k])) a_wild_r1: assert (fld_ok[k]);
  end
endmodule

// File: rtl/rtcai_ctrl_reg.sv
module rtcai_ctrl_reg
  import rtcai_pkg::*;
#(
  parameter int NCTL = N_CTL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NCTL-1:0] wdata,
  output logic [NCTL-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (we) en_q <= wdata;
  end

  p_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> en_q == $past(wdata));
endmodule

// File: rtl/rtcai_flag_core.sv
module rtcai_flag_core
  import rtcai_pkg::*;
#(
  parameter int NEVT = N_EVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic            rd,
  input  logic            we,
  input  logic [NEVT-1:0] wen,
  input  logic [NEVT-1:0] en,
  output logic [NEVT-1:0] flags,
  output logic            irqf
);
  logic [NEVT-1:0] base_fl, new_set, en_eff, nxt_fl;
  logic            base_irq, fire, pend_hit, nxt_irq;

  always_comb begin
    base_fl  = rd ? '0 : flags;
    base_irq = rd ? 1'b0 : irqf;
    new_set  = evt & ~base_fl;
    en_eff   = we ? wen : en;
    fire     = |(new_set & en_eff);
    pend_hit = |(wen & base_fl);
    nxt_fl   = base_fl | evt;
    nxt_irq  = we ? (pend_hit | fire) : (base_irq | fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irqf  <= 1'b0;
    end else begin
      flags <= nxt_fl;
      irqf  <= nxt_irq;
    end
  end

  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqf) |-> |(flags & en));
  p_rd_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !(|evt)) |=> (flags == '0) && !irqf);
  p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (flags & $past(evt)) == $past(evt));
  p_wr_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !(|evt) && !(|(wen & flags)) && !rd) |=> !irqf);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtcai_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_done,
  input  logic             per_tick,
  input  logic             div_hold,
  input  logic             mode_12h,
  input  logic [7:0]       cur_sec,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hr,
  input  logic [7:0]       alm_sec,
  input  logic [7:0]       alm_min,
  input  logic [7:0]       alm_hr,
  input  logic             ctrl_we,
  input  logic [3:0]       ctrl_wdata,
  input  logic             stat_rd,
  output logic [3:0]       ctrl_q,
  output logic [7:0]       stat_q,
  output logic             irq
);
  logic [N_FLD-1:0][BYTE_W-1:0] alm_v, cur_v;
  logic                         alarm_hit;
  logic                         upd_evt;
  logic [N_EVT-1:0]             evt_v;
  logic [N_EVT-1:0]             flags;
  logic                         irqf;

  assign alm_v[FLD_SEC] = alm_sec;
  assign alm_v[FLD_MIN] = alm_min;
  assign alm_v[FLD_HR]  = alm_hr;
  assign cur_v[FLD_SEC] = cur_sec;
  assign cur_v[FLD_MIN] = cur_min;
  assign cur_v[FLD_HR]  = cur_hr;

  rtcai_alarm_match #(.NFLD(N_FLD), .HOUR_IDX(FLD_HR)) u_match (
    .alm(alm_v), .cur(cur_v), .mode_12h(mode_12h), .hit(alarm_hit)
  );

  assign upd_evt        = upd_done && !div_hold;
  assign evt_v[EV_UPD]  = upd_evt;
  assign evt_v[EV_ALM]  = upd_evt && alarm_hit;
  assign evt_v[EV_PER]  = per_tick;

  rtcai_ctrl_reg #(.NCTL(N_CTL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .en_q(ctrl_q)
  );

  rtcai_flag_core #(.NEVT(N_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_v), .rd(stat_rd), .we(ctrl_we),
    .wen(ctrl_wdata[N_EVT-1:0]), .en(ctrl_q[N_EVT-1:0]),
    .flags(flags), .irqf(irqf)
  );

  assign stat_q = pack_status(irqf, flags);
  assign irq    = irqf;

  p_uf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !div_hold) |=> stat_q[4]);
  p_af_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !div_hold && alarm_hit) |=> stat_q[5]);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_hold && !stat_rd) |=> stat_q[5:4] == $past(stat_q[5:4]));
  p_pf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> stat_q[6]);
  p_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[3:0] == 4'h0);
endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_done = 0, per_tick = 0, div_hold = 0, mode_12h = 0;
  logic [7:0] cur_sec = 8'h45, cur_min = 8'h30, cur_hr = 8'h12;
  logic [7:0] alm_sec = 8'h59, alm_min = 8'h59, alm_hr = 8'h23;
  logic ctrl_we = 0;
  logic [3:0] ctrl_wdata = 0;
  logic stat_rd = 0;
  logic [3:0] ctrl_q;
  logic [7:0] stat_q;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse_upd();
    @(negedge clk) upd_done = 1;
    @(negedge clk) upd_done = 0;
    #1;
  endtask

  task automatic pulse_per();
    @(negedge clk) per_tick = 1;
    @(negedge clk) per_tick = 0;
    #1;
  endtask

  task automatic wr_ctl(logic [3:0] v);
    @(negedge clk) begin ctrl_we = 1; ctrl_wdata = v; end
    @(negedge clk) ctrl_we = 0;
    #1;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk) stat_rd = 1;
    #1 v = stat_q;
    @(negedge clk) stat_rd = 0;
    #1;
  endtask

  task automatic clean();
    logic [7:0] d;
    wr_ctl(4'h0);
    rd_stat(d);
  endtask

  task automatic t_reset_r8();
    wr_ctl(4'hF);
    chk("R8 ctrl written", {4'h0, ctrl_q}, 8'h0F);
    pulse_upd();
    @(negedge clk) rst_n = 0;
    #1;
    chk("R8 ctrl after reset", {4'h0, ctrl_q}, 8'h00);
    chk("R8 status after reset", stat_q, 8'h00);
    chk("R8 irq after reset", {7'h0, irq}, 8'h00);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic t_update_r2_r5();
    logic [7:0] v;
    clean();
    pulse_upd();
    chk("R2 update flag", stat_q, 8'h10);
    chk("R2 no irq when disabled", {7'h0, irq}, 8'h00);
    rd_stat(v);
    chk("R5 read value", v, 8'h10);
    chk("R5 cleared after read", stat_q, 8'h00);
  endtask

  task automatic t_irq_r4();
    clean();
    wr_ctl(4'h1);
    pulse_upd();
    chk("R4 update irq status", stat_q, 8'h90);
    chk("R4 irq line", {7'h0, irq}, 8'h01);
    begin logic [7:0] v; rd_stat(v); end
    chk("R5 irq lowered by read", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_alarm_r3();
    clean();
    alm_sec = 8'h45; alm_min = 8'h30; alm_hr = 8'h12;
    pulse_upd();
    chk("R3 exact alarm match", stat_q, 8'h30);
    clean();
    alm_sec = 8'h46;
    pulse_upd();
    chk("R3 seconds mismatch", stat_q, 8'h10);
    clean();
    wr_ctl(4'h2);
    alm_sec = 8'h45;
    pulse_upd();
    chk("R4 alarm irq", stat_q, 8'hB0);
  endtask

  task automatic t_wild_r1();
    clean();
    alm_sec = 8'hC0; alm_min = 8'hFF; alm_hr = 8'h12;
    pulse_upd();
    chk("R1 wildcard sec/min", stat_q, 8'h30);
    clean();
    alm_sec = 8'hC5; alm_min = 8'h31; alm_hr = 8'hC0;
    pulse_upd();
    chk("R1 wildcard does not hide minute mismatch", stat_q, 8'h10);
  endtask

  task automatic t_hour_r7();
    clean();
    alm_sec = 8'h45; alm_min = 8'h30; alm_hr = 8'h81;
    cur_hr = 8'h01; mode_12h = 1;
    pulse_upd();
    chk("R7 12h AM vs PM alarm", stat_q, 8'h10);
    clean();
    cur_hr = 8'h81;
    pulse_upd();
    chk("R7 12h PM match", stat_q, 8'h30);
    clean();
    cur_hr = 8'h01; mode_12h = 0;
    pulse_upd();
    chk("R7 24h ignores bit7", stat_q, 8'h30);
    cur_hr = 8'h12; alm_hr = 8'h23;
  endtask

  task automatic t_pending_r6();
    clean();
    pulse_upd();
    chk("R6 pending without irq", stat_q, 8'h10);
    wr_ctl(4'h1);
    chk("R6 enable pending raises", stat_q, 8'h90);
    chk("R6 irq raised", {7'h0, irq}, 8'h01);
    wr_ctl(4'h4);
    chk("R6 non-pending enable clears irqf", stat_q, 8'h10);
    chk("R6 irq lowered", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_hold_r9();
    clean();
    alm_sec = 8'hC0; alm_min = 8'hC0; alm_hr = 8'hC0;
    div_hold = 1;
    pulse_upd();
    chk("R9 hold blocks update and alarm", stat_q, 8'h00);
    div_hold = 0;
    alm_sec = 8'h59; alm_min = 8'h59; alm_hr = 8'h23;
  endtask

  task automatic t_periodic_r10();
    clean();
    pulse_per();
    chk("R10 periodic flag without enable", stat_q, 8'h40);
    clean();
    wr_ctl(4'h4);
    pulse_per();
    chk("R10 periodic irq", stat_q, 8'hC0);
  endtask

  task automatic t_coincide_r11();
    clean();
    pulse_upd();
    @(negedge clk) begin stat_rd = 1; per_tick = 1; end
    @(negedge clk) begin stat_rd = 0; per_tick = 0; end
    #1;
    chk("R11 event during read kept", stat_q, 8'h40);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R8 status in reset", stat_q, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_r8();
    t_update_r2_r5();
    t_irq_r4();
    t_alarm_r3();
    t_wild_r1();
    t_hour_r7();
    t_pending_r6();
    t_hold_r9();
    t_periodic_r10();
    t_coincide_r11();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule